// File: doc/BRIEF.md
# Automatic Modem Flow Controller

This block handles hardware flow control for a single serial channel. On the receive side it compares the receive FIFO fill count with a programmable trigger level. It raises a trigger interrupt, and it drives an active-low request output. That output is released (driven HIGH) once the FIFO fills past the trigger plus a hysteresis margin. It is driven LOW again only after the FIFO drains below the trigger minus that margin. The margin comes from a 4-bit code through a fixed table that is not monotonic.

On the transmit side, an active-low clear input is synchronised. A registered transmit-allowed flag then follows that input at character boundaries, so a character that is already being sent is never cut short. One select bit picks which modem pair the block uses: the request/clear pair, or the terminal-ready/set-ready pair. The output of the unused pair simply follows its host level.

When a feature is switched off, that path reverts to plain host control. The FIFO, the serializer and the register file sit outside this block.

Top module: `modem_flow_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `tx_allowed` is 1 and `rx_trig_irq` is 0.
- R2: The hysteresis code maps to characters as follows. Codes 0 to 7 give 0, 4, 6, 8, 8, 16, 24, 32. Codes 8 to 11 give 40, 44, 48, 52. Codes 12 to 15 give 12, 20, 28, 36.
- R3: One cycle after the count is at or above `trig_lvl` while `auto_req_en` is 1, `rx_trig_irq` is 1. It is 0 one cycle after the count is below the trigger, or after `auto_req_en` is 0.
- R4: While armed, the selected request output goes HIGH one cycle after `rx_count` reaches the upper threshold. The upper threshold is trigger plus hysteresis, saturated at the FIFO depth of 64.
- R5: Once HIGH, the selected request output stays HIGH until `rx_count` falls below the lower threshold (trigger minus hysteresis, clamped at 0). If that threshold is 0, it returns LOW once `rx_count` is 0. The change appears one cycle after the count does.
- R6: Automatic request control is armed only while the selected host level is 0 (asserted). While that level is 1, the selected output is 1 whatever the count.
- R7: With `auto_req_en` at 0, the selected request output equals the selected host level in the same cycle.
- R8: With `auto_clr_en` at 1, `tx_allowed` takes the inverse of the selected clear input on the third rising edge after that input changes, given that `char_bnd` is 1. While `char_bnd` is 0, `tx_allowed` holds its value.
- R9: `pair_sel`=0 selects `rts_n`/`cts_n`, and `pair_sel`=1 selects `dtr_n`/`dsr_n`. The unselected output equals its host level, and the unselected clear input has no effect on `tx_allowed`.
- R10: Clearing `auto_req_en` while the request is held HIGH returns it to the host level by the next cycle. Clearing `auto_clr_en` while transmit is blocked sets `tx_allowed` to 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_req_en | input | 1 | Enable automatic request control |
| auto_clr_en | input | 1 | Enable automatic transmit gating |
| pair_sel | input | 1 | 0: RTS/CTS pair, 1: DTR/DSR pair |
| hyst_code | input | 4 | Hysteresis code |
| trig_lvl | input | 7 | Receive trigger level in characters |
| rx_count | input | 7 | Receive FIFO fill count |
| host_rts_n | input | 1 | Host-written RTS level |
| host_dtr_n | input | 1 | Host-written DTR level |
| cts_n | input | 1 | Raw CTS pin, active low |
| dsr_n | input | 1 | Raw DSR pin, active low |
| char_bnd | input | 1 | Transmitter is at a character boundary |
| rts_n | output | 1 | RTS pin, active low |
| dtr_n | output | 1 | DTR pin, active low |
| tx_allowed | output | 1 | Transmitter may start a character |
| rx_trig_irq | output | 1 | Receive trigger interrupt |

## Verification
The hardest case to reach is the hysteresis band itself. With the request held HIGH, the count has to fall into the region between the two thresholds, and the bench must confirm the output does not follow it. It must also see that a later rise that stops short of the upper threshold leaves the output LOW. The bench gets there by pushing the count to the upper threshold and then stepping it down through the band, then back up. It does this for a non-clamped case, a case where the sum saturates at 64, and a case where the difference clamps to zero. For every table code it probes one below the upper threshold and then exactly at it.

// File: rtl/mfc_pkg.sv
// Shared constants and the hysteresis code table for the flow controller.
// Assumes the hysteresis never exceeds 63 characters.
package mfc_pkg;
    localparam int HYST_CODE_W = 4;
    localparam int HYST_W      = 6;

    // Maps a hysteresis code to a character count (table is non-monotonic).
    function automatic logic [HYST_W-1:0] hyst_chars(input logic [HYST_CODE_W-1:0] code);
        case (code)
            4'd0:  return 6'd0;
            4'd1:  return 6'd4;
            4'd2:  return 6'd6;
            4'd3:  return 6'd8;
            4'd4:  return 6'd8;
            4'd5:  return 6'd16;
            4'd6:  return 6'd24;
            4'd7:  return 6'd32;
            4'd8:  return 6'd40;
            4'd9:  return 6'd44;
            4'd10: return 6'd48;
            4'd11: return 6'd52;
            4'd12: return 6'd12;
            4'd13: return 6'd20;
            4'd14: return 6'd28;
            default: return 6'd36;
        endcase
    endfunction
endpackage

// File: rtl/mfc_thresh.sv
// Derives the upper (trigger + hysteresis, saturated at FIFO depth) and
// lower (trigger - hysteresis, clamped at zero) fill thresholds.
// Assumes CNT_W is wide enough to hold FIFO_DEPTH and the largest hysteresis.
module mfc_thresh
    import mfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 7
) (
    input  logic [CNT_W-1:0]       trig_lvl,
    input  logic [HYST_CODE_W-1:0] hyst_code,
    output logic [CNT_W-1:0]       upper,
    output logic [CNT_W-1:0]       lower
);
    localparam logic [CNT_W:0] DEPTH_V = (CNT_W+1)'(FIFO_DEPTH);

    logic [HYST_W-1:0] hyst;
    logic [CNT_W:0]    sum;
    logic [CNT_W-1:0]  hyst_c;

    // Saturating sum and clamping difference of trigger and hysteresis.
    always_comb begin
        hyst   = hyst_chars(hyst_code);
        hyst_c = CNT_W'(hyst);
        sum    = {1'b0, trig_lvl} + (CNT_W+1)'(hyst);
        upper  = (sum > DEPTH_V) ? DEPTH_V[CNT_W-1:0] : sum[CNT_W-1:0];
        lower  = (trig_lvl > hyst_c) ? (trig_lvl - hyst_c) : '0;
    end
endmodule

// File: rtl/mfc_req_ctl.sv
// Receive-side request control. Holds the request released between the
// upper and lower thresholds and raises the trigger interrupt.
// Assumes the thresholds are stable combinational inputs.
module mfc_req_ctl #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             host_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    input  logic [CNT_W-1:0] upper,
    input  logic [CNT_W-1:0] lower,
    output logic             req_n,
    output logic             irq
);
    logic active;
    logic release_q;
    logic reassert;

    // Armed only when enabled and the host has asserted the output.
    always_comb begin
        active   = en && !host_n;
        reassert = (count < lower) || ((lower == '0) && (count == '0));
        req_n    = active ? release_q : host_n;
    end

    // Hysteresis state: release at upper, re-assert below lower.
    always_ff @(posedge clk) begin
        if (!rst_n)               release_q <= 1'b0;
        else if (!active)         release_q <= 1'b0;
        else if (count >= upper)  release_q <= 1'b1;
        else if (reassert)        release_q <= 1'b0;
    end

    // Registered trigger interrupt while automatic request is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= en && (count >= trig);
    end
endmodule

// File: rtl/mfc_clr_gate.sv
// Transmit-side gating: synchronises both clear inputs, selects one and
// updates the transmit-allowed flag only at character boundaries.
// Assumes SYNC_STAGES >= 2.
module mfc_clr_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel,
    input  logic cts_n,
    input  logic dsr_n,
    input  logic char_bnd,
    output logic tx_allowed
);
    localparam int SH_W = 2 * SYNC_STAGES;

    logic [SH_W-1:0] sync_q;
    logic            clr_n_s;

    // Multi-stage synchroniser carrying both clear inputs side by side.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SH_W-3:0], dsr_n, cts_n};
    end

    // Pick the synchronised clear input of the selected pair.
    always_comb clr_n_s = sel ? sync_q[SH_W-1] : sync_q[SH_W-2];

    // Transmit permission, updated only between characters.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_allowed <= 1'b1;
        else if (!en)      tx_allowed <= 1'b1;
        else if (char_bnd) tx_allowed <= !clr_n_s;
    end
endmodule

// File: rtl/modem_flow_ctrl.sv
// Automatic modem flow controller for one serial channel: receive request
// with hysteresis, transmit gating from a clear input, and pair selection.
// Assumes rx_count never exceeds FIFO_DEPTH.
module modem_flow_ctrl
    import mfc_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   auto_req_en,
    input  logic                   auto_clr_en,
    input  logic                   pair_sel,
    input  logic [HYST_CODE_W-1:0] hyst_code,
    input  logic [CNT_W-1:0]       trig_lvl,
    input  logic [CNT_W-1:0]       rx_count,
    input  logic                   host_rts_n,
    input  logic                   host_dtr_n,
    input  logic                   cts_n,
    input  logic                   dsr_n,
    input  logic                   char_bnd,
    output logic                   rts_n,
    output logic                   dtr_n,
    output logic                   tx_allowed,
    output logic                   rx_trig_irq
);
    logic [CNT_W-1:0] upper;
    logic [CNT_W-1:0] lower;
    logic             host_sel_n;
    logic             req_sel_n;

    mfc_thresh #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) thresh_i (
        .trig_lvl (trig_lvl),
        .hyst_code(hyst_code),
        .upper    (upper),
        .lower    (lower)
    );

    // Host level of the selected request output.
    always_comb host_sel_n = pair_sel ? host_dtr_n : host_rts_n;

    mfc_req_ctl #(.CNT_W(CNT_W)) req_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (auto_req_en),
        .host_n(host_sel_n),
        .count (rx_count),
        .trig  (trig_lvl),
        .upper (upper),
        .lower (lower),
        .req_n (req_sel_n),
        .irq   (rx_trig_irq)
    );

    mfc_clr_gate #(.SYNC_STAGES(SYNC_STAGES)) clr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (auto_clr_en),
        .sel       (pair_sel),
        .cts_n     (cts_n),
        .dsr_n     (dsr_n),
        .char_bnd  (char_bnd),
        .tx_allowed(tx_allowed)
    );

    // Route the controlled level to the selected pin; the other follows host.
    always_comb begin
        rts_n = pair_sel ? host_rts_n : req_sel_n;
        dtr_n = pair_sel ? req_sel_n  : host_dtr_n;
    end
endmodule

// File: rtl/mfc_checker.sv
// Property checker for modem_flow_ctrl, attached with bind below.
module mfc_checker
    import mfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   auto_req_en,
    input logic                   auto_clr_en,
    input logic                   pair_sel,
    input logic [HYST_CODE_W-1:0] hyst_code,
    input logic [CNT_W-1:0]       trig_lvl,
    input logic [CNT_W-1:0]       rx_count,
    input logic                   host_rts_n,
    input logic                   host_dtr_n,
    input logic                   rts_n,
    input logic                   dtr_n,
    input logic                   tx_allowed,
    input logic                   rx_trig_irq
);
    logic [CNT_W:0]   up_sum;
    logic [CNT_W-1:0] up_ref;
    logic             host_s;
    logic             out_s;
    logic             armed;

    // Reference upper threshold and selected-pair views.
    always_comb begin
        up_sum = {1'b0, trig_lvl} + (CNT_W+1)'(hyst_chars(hyst_code));
        up_ref = (up_sum > (CNT_W+1)'(FIFO_DEPTH)) ? CNT_W'(FIFO_DEPTH) : up_sum[CNT_W-1:0];
        host_s = pair_sel ? host_dtr_n : host_rts_n;
        out_s  = pair_sel ? dtr_n : rts_n;
        armed  = auto_req_en && !host_s;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tx_allowed && !rx_trig_irq));

    // R3
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_req_en && rx_count >= trig_lvl) |=> rx_trig_irq);

    // R3
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_req_en |=> !rx_trig_irq);

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rx_count >= up_ref) |=> (!armed || !$stable(pair_sel) || out_s));

    // R6
    unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_req_en && host_s) |-> out_s);

    // R7
    gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_req_en |-> (out_s == host_s));

    // R9
    unsel_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_sel ? (rts_n == host_rts_n) : (dtr_n == host_dtr_n));

    // R10
    clr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_clr_en |=> tx_allowed);
endmodule

bind modem_flow_ctrl mfc_checker #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_req_en(auto_req_en),
    .auto_clr_en(auto_clr_en),
    .pair_sel   (pair_sel),
    .hyst_code  (hyst_code),
    .trig_lvl   (trig_lvl),
    .rx_count   (rx_count),
    .host_rts_n (host_rts_n),
    .host_dtr_n (host_dtr_n),
    .rts_n      (rts_n),
    .dtr_n      (dtr_n),
    .tx_allowed (tx_allowed),
    .rx_trig_irq(rx_trig_irq)
);

// File: tb/modem_flow_ctrl_tb_top.sv
// Directed bench for modem_flow_ctrl; one task per scenario.
module modem_flow_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_req_en = 1'b0;
    logic       auto_clr_en = 1'b0;
    logic       pair_sel = 1'b0;
    logic [3:0] hyst_code = 4'd0;
    logic [6:0] trig_lvl = 7'd12;
    logic [6:0] rx_count = 7'd0;
    logic       host_rts_n = 1'b1;
    logic       host_dtr_n = 1'b1;
    logic       cts_n = 1'b0;
    logic       dsr_n = 1'b0;
    logic       char_bnd = 1'b1;
    logic       rts_n, dtr_n, tx_allowed, rx_trig_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    modem_flow_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .auto_req_en(auto_req_en), .auto_clr_en(auto_clr_en),
        .pair_sel(pair_sel), .hyst_code(hyst_code), .trig_lvl(trig_lvl), .rx_count(rx_count),
        .host_rts_n(host_rts_n), .host_dtr_n(host_dtr_n), .cts_n(cts_n), .dsr_n(dsr_n),
        .char_bnd(char_bnd), .rts_n(rts_n), .dtr_n(dtr_n), .tx_allowed(tx_allowed),
        .rx_trig_irq(rx_trig_irq)
    );

    function automatic int ref_hyst(input int code);
        int tbl[16] = '{0, 4, 6, 8, 8, 16, 24, 32, 40, 44, 48, 52, 12, 20, 28, 36};
        return tbl[code];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_count(input int c);
        rx_count = 7'(c);
        step(1);
    endtask

    task automatic t_reset();
        step(2);
        check("R1 tx_allowed in reset", tx_allowed, 1);
        check("R1 irq in reset", rx_trig_irq, 0);
        rst_n = 1'b1;
        step(1);
        check("R1 tx_allowed after reset", tx_allowed, 1);
        check("R1 irq after reset", rx_trig_irq, 0);
    endtask

    task automatic t_table();
        auto_req_en = 1'b1; host_rts_n = 1'b0; trig_lvl = 7'd12;
        for (int c = 0; c < 16; c++) begin
            int up;
            up = 12 + ref_hyst(c);
            hyst_code = 4'(c);
            set_count(0);
            set_count(up - 1);
            check($sformatf("R2 code %0d below upper", c), rts_n, 0);
            set_count(up);
            check($sformatf("R2 code %0d at upper", c), rts_n, 1);
            set_count(0);
            check($sformatf("R2 code %0d drained", c), rts_n, 0);
        end
    endtask

    task automatic t_irq();
        auto_req_en = 1'b1; trig_lvl = 7'd12;
        set_count(11);
        check("R3 irq below trigger", rx_trig_irq, 0);
        set_count(12);
        check("R3 irq at trigger", rx_trig_irq, 1);
        auto_req_en = 1'b0;
        step(1);
        check("R3 irq when disabled", rx_trig_irq, 0);
        set_count(0);
    endtask

    task automatic t_band();
        auto_req_en = 1'b1; host_rts_n = 1'b0; trig_lvl = 7'd40; hyst_code = 4'd5;
        set_count(56);
        check("R4 release at 56", rts_n, 1);
        set_count(30);
        check("R5 held inside band", rts_n, 1);
        set_count(24);
        check("R5 held at lower", rts_n, 1);
        set_count(23);
        check("R5 reassert below lower", rts_n, 0);
        set_count(55);
        check("R5 rise short of upper", rts_n, 0);
        set_count(56);
        check("R4 release again", rts_n, 1);
        set_count(0);
    endtask

    task automatic t_sat();
        auto_req_en = 1'b1; host_rts_n = 1'b0; trig_lvl = 7'd40; hyst_code = 4'd11;
        set_count(63);
        check("R4 saturated below 64", rts_n, 0);
        set_count(64);
        check("R4 saturated at 64", rts_n, 1);
        set_count(0);
    endtask

    task automatic t_clamp();
        auto_req_en = 1'b1; host_rts_n = 1'b0; trig_lvl = 7'd20; hyst_code = 4'd7;
        set_count(64);
        check("R5 clamp released", rts_n, 1);
        set_count(1);
        check("R5 clamp held at 1", rts_n, 1);
        set_count(0);
        check("R5 clamp reassert at 0", rts_n, 0);
    endtask

    task automatic t_arm();
        auto_req_en = 1'b1; host_rts_n = 1'b1; trig_lvl = 7'd12; hyst_code = 4'd0;
        set_count(0);
        check("R6 unarmed low count", rts_n, 1);
        host_rts_n = 1'b0;
        #1;
        check("R6 armed low count", rts_n, 0);
        set_count(64);
        check("R6 armed releases", rts_n, 1);
        set_count(0);
    endtask

    task automatic t_gpio();
        auto_req_en = 1'b0; host_rts_n = 1'b0;
        set_count(64);
        check("R7 gpio low", rts_n, 0);
        host_rts_n = 1'b1;
        step(1);
        check("R7 gpio high", rts_n, 1);
        set_count(0);
    endtask

    task automatic t_clr();
        auto_clr_en = 1'b1; char_bnd = 1'b1; cts_n = 1'b1;
        step(2);
        check("R8 not yet through sync", tx_allowed, 1);
        step(1);
        check("R8 blocked on third edge", tx_allowed, 0);
        char_bnd = 1'b0; cts_n = 1'b0;
        step(4);
        check("R8 held mid-character", tx_allowed, 0);
        char_bnd = 1'b1;
        step(1);
        check("R8 resumes at boundary", tx_allowed, 1);
    endtask

    task automatic t_sel();
        pair_sel = 1'b1; auto_req_en = 1'b1; host_dtr_n = 1'b0; host_rts_n = 1'b1;
        trig_lvl = 7'd12; hyst_code = 4'd0;
        set_count(12);
        check("R9 dtr released", dtr_n, 1);
        check("R9 rts follows host high", rts_n, 1);
        host_rts_n = 1'b0;
        step(1);
        check("R9 rts follows host low", rts_n, 0);
        auto_clr_en = 1'b1; cts_n = 1'b1; dsr_n = 1'b0;
        step(3);
        check("R9 cts ignored", tx_allowed, 1);
        dsr_n = 1'b1;
        step(3);
        check("R9 dsr blocks", tx_allowed, 0);
        dsr_n = 1'b0; cts_n = 1'b0; pair_sel = 1'b0; host_dtr_n = 1'b1;
        set_count(0);
        step(3);
    endtask

    task automatic t_disable();
        auto_req_en = 1'b1; host_rts_n = 1'b0; trig_lvl = 7'd12; hyst_code = 4'd0;
        set_count(64);
        check("R10 held before disable", rts_n, 1);
        auto_req_en = 1'b0;
        step(1);
        check("R10 request back to host", rts_n, 0);
        auto_clr_en = 1'b1; cts_n = 1'b1;
        step(3);
        check("R10 blocked before disable", tx_allowed, 0);
        auto_clr_en = 1'b0;
        step(1);
        check("R10 allowed after disable", tx_allowed, 1);
        cts_n = 1'b0;
        set_count(0);
    endtask

    initial begin
        t_reset();
        t_table();
        t_irq();
        t_band();
        t_sat();
        t_clamp();
        t_arm();
        t_gpio();
        t_clr();
        t_sel();
        t_disable();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule